// File: doc/BRIEF.md
# System Tick Countdown Timer

A periodic down-counter meant to produce the regular heartbeat interrupt of a processor subsystem. Software programs a reload value and then enables counting. On each selected tick the counter drops by one. When a decrement lands on zero the block raises a count flag and, if allowed, pulses its interrupt line for one cycle. The counter then rests at zero for one further tick before it reloads and starts the next period.

Two tick-enable inputs feed the block. They are a reference tick and a core tick, and a control bit picks which one advances the counter. Access is through a small synchronous register port with word offsets for control/status, reload value, current value and a fixed calibration word. The counter can be cleared at any time by writing to the current-value register. A zero reload value halts counting after the next expiry, but the enable bit stays as software wrote it.

Top module: `tick_timer`

## Requirements
- R1: After reset the control/status, reload and current-value registers read zero, the interrupt output is low, and the calibration register (offset 0xC) reads 10000.
- R2: Registers sit at offset 0x0 (control/status), 0x4 (reload), 0x8 (current value) and 0xC (calibration). In control/status, bit 0 is enable, bit 1 is interrupt enable, bit 2 is clock-source select, and bit 16 is the count flag. All other bits read zero. A read of any other offset returns zero, a write to any other offset changes nothing, and read data is zero when no read is requested.
- R3: A write to the reload register stores only bits [23:0] of the write data.
- R4: While enabled and not halted, the counter drops by one on each selected tick. While the enable bit is 0 the counter does not change.
- R5: With clock-source select at 0 the reference tick advances the counter. With it at 1 the core tick does.
- R6: After a decrement to zero the counter stays at zero for one selected tick. On the following selected tick it loads the reload value.
- R7: Setting the enable bit from 0 to 1 does not load the counter at once. A zero counter loads the reload value on the first selected tick after enabling.
- R8: Any write to the current-value register makes the counter zero and clears the count flag. It raises no interrupt, even if a tick arrives in the same cycle. If the reload value is zero at that moment, counting halts.
- R9: The count flag is set by a decrement to zero. A read of control/status returns the flag and then clears it, but an expiry in the same cycle leaves it set.
- R10: With interrupt enable set, a decrement to zero produces a one-cycle interrupt pulse in the cycle after that tick. No pulse occurs otherwise.
- R11: If the reload value is zero when the counter reaches zero, counting halts and the enable bit still reads 1. Writing enable from 0 to 1 restarts counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 4 | Register byte offset |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid in the cycle of rdEn |
| tickRef | input | 1 | Reference tick enable |
| tickCore | input | 1 | Core tick enable |
| irq | output | 1 | One-cycle expiry interrupt pulse |

## Verification
The bench builds the block with its default parameters: a 24-bit counter, a 32-bit data port and a calibration value of 10000. Reload values of 0, 1 and a few units bring expiry, the zero rest tick, back-to-back interrupts and the zero-reload halt within a handful of ticks. A reload write with high garbage bits exercises the 24-bit mask. Running the two tick inputs at different rates makes the clock-source choice visible in the count sequence.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_RELOAD = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_CURRENT = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_CALIB = 4'hC;
  localparam int BIT_EN = 0;
  localparam int BIT_IE = 1;
  localparam int BIT_SRC = 2;
  localparam int BIT_FLAG = 16;

  typedef struct packed {
    logic step;   // advance counter on this cycle
    logic clear;  // force counter to zero (has priority)
  } dp_cmd_t;
endpackage

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_cmd_t          cmd,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] cnt,
  output logic             cntIsZero,
  output logic             cntIsOne
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign cntIsZero = (cnt == '0);
  assign cntIsOne = (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cmd.clear) begin
      cnt <= '0;
    end else if (cmd.step) begin
      cnt <= cntIsZero ? reloadVal : cnt - ONE;
    end
  end
endmodule

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrLow,
  input  logic              tickRef,
  input  logic              tickCore,
  input  logic              cntIsZero,
  input  logic              cntIsOne,
  output dp_cmd_t           cmd,
  output logic [CNT_W-1:0]  reloadQ,
  output logic              enableQ,
  output logic              intEnQ,
  output logic              srcQ,
  output logic              flagQ,
  output logic              irq
);
  logic ctrlWr, reloadWr, curWr, ctrlRd;
  logic tickSel, step, expiry, haltNow, halted, reloadZero;

  assign ctrlWr = wrEn && (addr == OFF_CTRL);
  assign reloadWr = wrEn && (addr == OFF_RELOAD);
  assign curWr = wrEn && (addr == OFF_CURRENT);
  assign ctrlRd = rdEn && (addr == OFF_CTRL);

  assign tickSel = srcQ ? tickCore : tickRef;
  assign step = enableQ && !halted && tickSel;
  assign reloadZero = (reloadQ == '0);
  assign expiry = step && cntIsOne && !curWr;
  assign haltNow = (step && reloadZero && (cntIsZero || cntIsOne)) ||
                   (curWr && reloadZero);

  assign cmd.step = step;
  assign cmd.clear = curWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      intEnQ <= 1'b0;
      srcQ <= 1'b0;
      reloadQ <= '0;
      flagQ <= 1'b0;
      halted <= 1'b0;
      irq <= 1'b0;
    end else begin
      if (ctrlWr) begin
        enableQ <= wrLow[BIT_EN];
        intEnQ <= wrLow[BIT_IE];
        srcQ <= wrLow[BIT_SRC];
      end
      if (reloadWr) reloadQ <= wrLow;
      if (expiry) flagQ <= 1'b1;
      else if (curWr || ctrlRd) flagQ <= 1'b0;
      if (ctrlWr && !enableQ && wrLow[BIT_EN]) halted <= 1'b0;
      else if (haltNow) halted <= 1'b1;
      irq <= expiry && intEnQ;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] CAL_VAL = 32'd10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              tickRef,
  input  logic              tickCore,
  output logic              irq
);
  dp_cmd_t cmd;
  logic [CNT_W-1:0] cnt, reloadQ;
  logic cntIsZero, cntIsOne, enableQ, intEnQ, srcQ, flagQ;
  logic unusedBits;

  assign unusedBits = ^wrData[DATA_W-1:CNT_W];

  tick_timer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrLow(wrData[CNT_W-1:0]), .tickRef(tickRef), .tickCore(tickCore),
    .cntIsZero(cntIsZero), .cntIsOne(cntIsOne), .cmd(cmd),
    .reloadQ(reloadQ), .enableQ(enableQ), .intEnQ(intEnQ), .srcQ(srcQ),
    .flagQ(flagQ), .irq(irq)
  );

  tick_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .reloadVal(reloadQ),
    .cnt(cnt), .cntIsZero(cntIsZero), .cntIsOne(cntIsOne)
  );

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (addr)
        OFF_CTRL: begin
          rdData[BIT_EN] = enableQ;
          rdData[BIT_IE] = intEnQ;
          rdData[BIT_SRC] = srcQ;
          rdData[BIT_FLAG] = flagQ;
        end
        OFF_RELOAD: rdData[CNT_W-1:0] = reloadQ;
        OFF_CURRENT: rdData[CNT_W-1:0] = cnt;
        OFF_CALIB: rdData = CAL_VAL;
        default: rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic              irq,
  input logic              enableQ,
  input logic              flagQ,
  input logic              cmdStep,
  input logic              cmdClear,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  reloadQ
);
  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  // R9
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> flagQ);

  // R8
  cur_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFF_CURRENT) |=> (cnt == '0) && !flagQ && !irq);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enableQ && !(wrEn && addr == OFF_CURRENT)) |=> $stable(cnt));

  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStep && !cmdClear && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));

  // R6
  zero_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStep && !cmdClear && cnt == '0) |=> cnt == $past(reloadQ));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .irq(irq),
  .enableQ(enableQ), .flagQ(flagQ), .cmdStep(cmd.step),
  .cmdClear(cmd.clear), .cnt(cnt), .reloadQ(reloadQ)
);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic tickRef = 1'b0, tickCore = 1'b0;
  logic irq;

  int vectors = 0, errors = 0;
  int refDiv = 0, coreDiv = 0, cyc = 0;
  bit done = 0;
  string curReq = "R1";

  // behavioural reference state
  bit mEn, mIe, mSrc, mFlag, mHalt, mIrq;
  int unsigned mRel, mCnt;

  tick_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .tickRef(tickRef),
    .tickCore(tickCore), .irq(irq)
  );

  initial forever begin #4 clk = 1'b1; #4 clk = 1'b0; end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tickRef <= (refDiv != 0) && (cyc % refDiv == 0);
    tickCore <= (coreDiv != 0) && (cyc % coreDiv == 0);
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mIe = 0; mSrc = 0; mFlag = 0; mHalt = 0; mIrq = 0;
      mRel = 0; mCnt = 0;
    end else begin
      bit tk, exp, nHalt, nFlag;
      int unsigned nCnt;
      tk = mSrc ? tickCore : tickRef;
      exp = 0; nCnt = mCnt; nHalt = mHalt; nFlag = mFlag;
      if (mEn && !mHalt && tk) begin
        if (mCnt == 0) begin
          if (mRel == 0) nHalt = 1; else nCnt = mRel;
        end else begin
          nCnt = mCnt - 1;
          if (mCnt == 1) begin
            exp = 1;
            if (mRel == 0) nHalt = 1;
          end
        end
      end
      if (rdEn && addr == 4'h0) nFlag = 0;
      if (wrEn) begin
        case (addr)
          4'h0: begin
            if (!mEn && wrData[0]) nHalt = 0;
            mEn = wrData[0]; mIe = wrData[1]; mSrc = wrData[2];
          end
          4'h4: mRel = wrData & 32'h00FF_FFFF;
          4'h8: begin
            nCnt = 0; exp = 0; nFlag = 0;
            if (mRel == 0) nHalt = 1;
          end
          default: ;
        endcase
      end
      if (exp) nFlag = 1;
      mIrq = exp && mIe;
      mCnt = nCnt; mHalt = nHalt; mFlag = nFlag;
    end
  end

  function automatic logic [31:0] modelRead(logic [3:0] a);
    case (a)
      4'h0: return {15'd0, mFlag, 13'd0, mSrc, mIe, mEn};
      4'h4: return mRel;
      4'h8: return mCnt;
      4'hC: return 32'd10000;
      default: return 32'd0;
    endcase
  endfunction

  always @(negedge clk) begin
    #3;
    if (rstN && !done) begin
      logic [31:0] exp;
      exp = rdEn ? modelRead(addr) : 32'd0;
      vectors++;
      if (rdData !== exp) begin
        errors++;
        $display("FAIL %s rdData addr=%h actual=%h expected=%h", curReq, addr, rdData, exp);
      end
      vectors++;
      if (irq !== mIrq) begin
        errors++;
        $display("FAIL %s irq actual=%b expected=%b", curReq, irq, mIrq);
      end
    end
  end

  task automatic idle(int n, string req);
    repeat (n) begin
      @(negedge clk);
      curReq = req; wrEn = 0; rdEn = 1; addr = 4'h8;
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, string req);
    @(negedge clk);
    curReq = req; wrEn = 1; rdEn = 0; addr = a; wrData = d;
  endtask

  task automatic rd(logic [3:0] a, string req);
    @(negedge clk);
    curReq = req; wrEn = 0; rdEn = 1; addr = a;
  endtask

  initial begin
    #800_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(4'h0, "R1"); rd(4'h4, "R1"); rd(4'h8, "R1"); rd(4'hC, "R1");
    // R2 unmapped offsets and no-read data
    rd(4'h2, "R2"); rd(4'h6, "R2"); rd(4'hF, "R2");
    wr(4'h3, 32'hFFFF_FFFF, "R2"); wr(4'hD, 32'h7, "R2");
    rd(4'h0, "R2"); rd(4'h4, "R2");
    @(negedge clk); curReq = "R2"; rdEn = 0; wrEn = 0;
    // R3 reload mask
    wr(4'h4, 32'hAB00_0005, "R3"); rd(4'h4, "R3");
    // R7 enable, reference tick every 3rd cycle, core every cycle
    refDiv = 3; coreDiv = 1;
    wr(4'h0, 32'h3, "R7"); idle(8, "R7");
    // R4 R6 R10 periodic counting
    idle(40, "R6"); rd(4'h0, "R9"); rd(4'h0, "R9"); idle(10, "R10");
    // R5 switch to core tick
    wr(4'h0, 32'h7, "R5"); idle(30, "R5");
    rd(4'h0, "R9"); idle(6, "R9"); rd(4'h0, "R9");
    // R8 clear current value mid-count
    idle(2, "R8"); wr(4'h8, 32'h1234, "R8"); idle(3, "R8");
    wr(4'h4, 32'h0000_0009, "R8"); idle(4, "R8");
    wr(4'h8, 32'h0, "R8"); rd(4'h0, "R8"); idle(12, "R8");
    // R4 disabled counter holds
    wr(4'h0, 32'h6, "R4"); idle(15, "R4"); rd(4'h0, "R4");
    wr(4'h0, 32'h7, "R4"); idle(5, "R4");
    // R11 zero reload halts, enable stays
    wr(4'h4, 32'h0, "R11"); idle(25, "R11"); rd(4'h0, "R11"); idle(5, "R11");
    // R10 reload of 1 gives pulses every other tick after restart
    wr(4'h4, 32'h1, "R10"); wr(4'h0, 32'h6, "R10"); wr(4'h0, 32'h7, "R10");
    idle(20, "R10"); rd(4'h0, "R9");
    // R8 write to current value with zero reload halts
    wr(4'h4, 32'h0, "R8"); wr(4'h8, 32'h5, "R8"); idle(8, "R8");
    rd(4'h0, "R11"); rd(4'hC, "R1");
    // R5 reference-tick source again, interrupt disabled
    wr(4'h4, 32'h4, "R5"); wr(4'h0, 32'h0, "R5"); wr(4'h0, 32'h1, "R5");
    refDiv = 2; idle(40, "R5"); rd(4'h0, "R9");
    idle(2, "R5");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule